// File: doc/BRIEF.md
# Stack Frame Entry/Exit Unit

This unit executes three stack-management commands for a 32-bit processor core. The commands are a stack-pointer adjust, a function-entry frame setup and a function-exit frame teardown. The core supplies the current frame pointer and stack pointer with each command. The unit then performs at most one word-wide memory access through a request/ready handshake. It returns both updated pointer values together with a one-cycle completion pulse.

Each command carries an 8-bit immediate that the unit scales by four. For the adjust command the immediate is a signed word count. For the entry command it is an unsigned frame size in words.

Entry saves the old frame pointer just below the current stack top. It moves the frame pointer to that slot and then drops the stack pointer by the frame size. Exit undoes this: the stack pointer returns to the frame pointer plus four, and the frame pointer is reloaded from the word it points at. The unit neither reads nor changes the condition flags. While a command is in flight, the unit ignores any new command.

Top module: `frame_stack_unit`

## Requirements
- R1: Opcode 0xA3 (adjust) produces `done` in the cycle after acceptance. In that cycle `sp_out` equals `sp_in + sign_extend(cmd_imm) * 4` and `fp_out` equals `fp_in`, and no memory request is made.
- R2: Opcode 0x0F (entry) raises a write request (`mem_we`=1) in the cycle after acceptance. The request carries `mem_addr` = `sp_in - 4` and `mem_wdata` = `fp_in`.
- R3: For an entry, `done` rises in the cycle after the memory handshake. At that point `fp_out` = `sp_in - 4` and `sp_out` = `sp_in - zero_extend(cmd_imm) * 4`, both computed from the original stack pointer.
- R4: Opcode 0x9F (exit) raises a read request (`mem_we`=0) at `mem_addr` = `fp_in`. In the cycle after the handshake, `done` rises with `sp_out` = `fp_in + 4` and `fp_out` = the word returned on `mem_rdata`.
- R5: A memory request, with its address, direction and write data, stays unchanged until `mem_ready` is sampled high at a rising edge. Any number of wait cycles is allowed.
- R6: `busy` is high from the cycle after acceptance through the `done` cycle. A `cmd_valid` seen while `busy` is high has no effect.
- R7: A command whose opcode is none of 0xA3, 0x0F or 0x9F is ignored: `busy`, `done` and `mem_req` stay low.
- R8: `done` is a single-cycle pulse. After reset, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present; accepted when not busy |
| cmd_op | input | 8 | Command opcode |
| cmd_imm | input | 8 | Scaled immediate (words) |
| fp_in | input | XLEN | Current frame pointer |
| sp_in | input | XLEN | Current stack pointer |
| busy | output | 1 | Command in flight |
| done | output | 1 | Results valid this cycle |
| fp_out | output | XLEN | Updated frame pointer |
| sp_out | output | XLEN | Updated stack pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | XLEN | Word-aligned byte address |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory accepts/returns this cycle |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path and opcodes 0xA3, 0x0F and 0x9F. At this width, an adjust with the most negative immediate (-512 bytes) wraps below address zero, and an entry with the largest frame size (1020 bytes) is exercised. The bench memory responder is given latencies of zero to several cycles. This lets the request-holding rule and the ignore-while-busy rule be observed over long stalls. An entry is also followed by an exit so that the original frame is restored.

// File: rtl/frame_stack_unit.sv
module frame_stack_unit #(
  parameter int          XLEN     = 32,
  parameter logic [7:0]  OP_ADJ   = 8'hA3,
  parameter logic [7:0]  OP_ENTER = 8'h0F,
  parameter logic [7:0]  OP_LEAVE = 8'h9F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [7:0]      cmd_op,
  input  logic [7:0]      cmd_imm,
  input  logic [XLEN-1:0] fp_in,
  input  logic [XLEN-1:0] sp_in,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] fp_out,
  output logic [XLEN-1:0] sp_out,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_ready
);

  localparam int PADW = XLEN - 10;
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_DONE} state_t;
  state_t state;

  logic [XLEN-1:0] imm_sx4, imm_zx4;
  logic            accept;

  assign imm_sx4 = {{PADW{cmd_imm[7]}}, cmd_imm, 2'b00};
  assign imm_zx4 = {{PADW{1'b0}}, cmd_imm, 2'b00};
  assign accept  = cmd_valid && (state == S_IDLE);
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      fp_out    <= '0;
      sp_out    <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          if (cmd_op == OP_ADJ) begin
            sp_out <= sp_in + imm_sx4;
            fp_out <= fp_in;
            state  <= S_DONE;
          end else if (cmd_op == OP_ENTER) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= sp_in - WORD;
            mem_wdata <= fp_in;
            fp_out    <= sp_in - WORD;
            sp_out    <= sp_in - imm_zx4;
            state     <= S_MEM;
          end else if (cmd_op == OP_LEAVE) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= fp_in;
            sp_out   <= fp_in + WORD;
            state    <= S_MEM;
          end
        end
        S_MEM: if (mem_ready) begin
          mem_req <= 1'b0;
          if (!mem_we) fp_out <= mem_rdata;
          state <= S_DONE;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R5
  AST_ADJ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == OP_ADJ) |=> (done && !mem_req && fp_out == $past(fp_in))); // R1
  AST_ENTER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == OP_ENTER) |=> (mem_req && mem_we && mem_wdata == $past(fp_in))); // R2
  AST_HANDSHAKE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (done && !mem_req)); // R3
  AST_LEAVE_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == OP_LEAVE) |=> (mem_req && !mem_we && mem_addr == $past(fp_in))); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R6
  AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op != OP_ADJ && cmd_op != OP_ENTER && cmd_op != OP_LEAVE) |=> !busy); // R7

endmodule

// File: tb/frame_stack_unit_tb_top.sv
`timescale 1ns/1ps
module frame_stack_unit_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, cmd_valid, busy, done, mem_req, mem_we, mem_ready;
  logic [7:0]  cmd_op, cmd_imm;
  logic [31:0] fp_in, sp_in, fp_out, sp_out, mem_addr, mem_wdata, mem_rdata;

  frame_stack_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_imm(cmd_imm),
    .fp_in(fp_in), .sp_in(sp_in), .busy(busy), .done(done), .fp_out(fp_out), .sp_out(sp_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready));

  int errors = 0, checks = 0;
  logic [31:0] mem [256];

  int          ph = 0;
  logic [31:0] e_fp, e_sp, e_addr, e_wd;
  bit          e_we;
  string       op_tag = "R1", mem_tag = "R2", st_tag = "R8";
  int          lat = 0, wcnt = 0;
  bit          seen = 0;
  bit          finished = 0;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else begin
      case (ph)
        0: if (cmd_valid) begin
          if (cmd_op == 8'hA3) begin
            e_sp = sp_in + 32'(int'($signed(cmd_imm)) * 4);
            e_fp = fp_in; op_tag = "R1"; ph = 2;
          end else if (cmd_op == 8'h0F) begin
            e_addr = sp_in - 4; e_we = 1; e_wd = fp_in;
            e_fp = sp_in - 4; e_sp = sp_in - 32'(int'(cmd_imm) * 4);
            op_tag = "R3"; mem_tag = "R2"; ph = 1;
          end else if (cmd_op == 8'h9F) begin
            e_addr = fp_in; e_we = 0; e_sp = fp_in + 4;
            op_tag = "R4"; mem_tag = "R4"; ph = 1;
          end
        end
        1: if (mem_ready) begin
          if (e_we) mem[e_addr[9:2]] = mem_wdata;
          else e_fp = mem[e_addr[9:2]];
          ph = 2;
        end
        default: ph = 0;
      endcase
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy == (ph != 0), st_tag, "busy", 32'(busy), 32'(ph != 0));
      chk(done == (ph == 2), st_tag, "done", 32'(done), 32'(ph == 2));
      chk(mem_req == (ph == 1), "R5", "mem_req", 32'(mem_req), 32'(ph == 1));
      if (ph == 1) begin
        chk(mem_addr == e_addr, mem_tag, "mem_addr", mem_addr, e_addr);
        chk(mem_we == e_we, mem_tag, "mem_we", 32'(mem_we), 32'(e_we));
        if (e_we) chk(mem_wdata == e_wd, mem_tag, "mem_wdata", mem_wdata, e_wd);
      end
      if (ph == 2) begin
        chk(fp_out == e_fp, op_tag, "fp_out", fp_out, e_fp);
        chk(sp_out == e_sp, op_tag, "sp_out", sp_out, e_sp);
      end
    end
  end

  // memory responder with variable latency
  always @(negedge clk) begin
    if (!rst_n) begin mem_ready = 0; seen = 0; end
    else if (mem_req && !mem_ready) begin
      if (!seen) begin seen = 1; wcnt = lat; end
      if (wcnt == 0) begin mem_ready = 1; mem_rdata = mem[mem_addr[9:2]]; end
      else wcnt--;
    end else if (!mem_req) begin
      mem_ready = 0; seen = 0; mem_rdata = 32'hDEAD_BEEF;
    end
  end

  task automatic issue(logic [7:0] op, logic [7:0] imm, logic [31:0] fp, logic [31:0] sp, int l);
    @(negedge clk);
    lat = l; cmd_valid = 1; cmd_op = op; cmd_imm = imm; fp_in = fp; sp_in = sp;
    @(negedge clk);
    cmd_valid = 0; fp_in = ~fp; sp_in = ~sp; cmd_imm = ~imm;
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0101_0101 * i;
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_imm = 0; fp_in = 0; sp_in = 0;
    mem_ready = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R8", "reset outputs", {29'd0, busy, done, mem_req}, 0);
    rst_n = 1;

    st_tag = "R8";
    issue(8'hA3, 8'h05, 32'h0000_0300, 32'h0000_0200, 0);   // R1 positive
    issue(8'hA3, 8'h80, 32'h0000_0300, 32'h0000_0100, 0);   // R1 wraps below zero
    issue(8'hA3, 8'h7F, 32'h1234_5678, 32'h0000_0040, 0);   // R1 max positive

    issue(8'h0F, 8'h10, 32'h0000_0380, 32'h0000_0200, 0);   // R2 R3 zero wait
    chk(mem[8'h7F] == 32'h0000_0380, "R2", "saved frame pointer", mem[8'h7F], 32'h0000_0380);
    issue(8'h9F, 8'h00, 32'h0000_01FC, 32'h0000_01BC, 2);   // R4 restores frame
    chk(sp_out == 32'h0000_0200 && fp_out == 32'h0000_0380, "R4", "exit restores",
        fp_out, 32'h0000_0380);

    issue(8'h0F, 8'hFF, 32'h0000_0100, 32'h0000_0800, 5);   // R3 R5 max frame, long wait
    issue(8'h9F, 8'h00, 32'h0000_0020, 32'h0000_0000, 7);   // R4 R5 long wait

    // R6: commands presented while busy are ignored
    st_tag = "R6";
    @(negedge clk);
    lat = 4; cmd_valid = 1; cmd_op = 8'h0F; cmd_imm = 8'h02; fp_in = 32'h0000_0044; sp_in = 32'h0000_0080;
    @(negedge clk);
    cmd_op = 8'hA3; cmd_imm = 8'h40; fp_in = 32'hAAAA_0000; sp_in = 32'h5555_0000;
    while (busy) @(negedge clk);
    cmd_valid = 0;
    chk(fp_out == 32'h0000_007C && sp_out == 32'h0000_0078, "R6", "busy ignore result",
        sp_out, 32'h0000_0078);

    // R7: unknown opcode ignored
    st_tag = "R7";
    @(negedge clk);
    cmd_valid = 1; cmd_op = 8'h55; cmd_imm = 8'h01;
    @(negedge clk);
    cmd_valid = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req, "R7", "unknown opcode idle", {30'd0, busy, mem_req}, 0);

    st_tag = "R8";
    issue(8'hA3, 8'hFF, 32'h0, 32'h0000_0010, 0);           // R1 minus one word
    repeat (2) @(negedge clk);
    summary();
  end
endmodule